// File: doc/BRIEF.md
# Programmable Interval Counter Channel (Rate Generator)

This block is a single 16-bit down-counting channel of an interval timer. It advances on a fixed-rate tick strobe, nominally near 1.19 MHz, that comes from the system clock domain. A host programs the channel over a byte-wide bus with two addresses, one for control and one for data. It first writes a control word. It then writes a 16-bit initial count as two bytes, low byte first. It can read back the live count at any time, also as two bytes with the low byte first.

Once loaded, the channel runs as a rate generator. It counts down one step per tick while an external gate level is high. When the count reaches one, it drops its output for exactly one tick and then reloads itself. The output therefore repeats with a period equal to the initial count, in ticks. A zero count means the full 65,536-tick span, about 54.9 ms at the nominal rate. Software can also poll the live count to build delays that do not depend on the processor's speed.

Top module: `pit_rate_channel`

## Requirements
- R1: A control-address write is accepted only for the value 0xB4. Bits [7:6]=10 select this channel, bits [5:4]=11 select low-then-high byte access, bits [3:1]=010 select the rate-generator mode, and bit 0=0 selects binary counting. Any other value leaves the count, the output and both byte pointers unchanged.
- R2: After an accepted control word, the first data write stores the low byte and the second stores the high byte. The first tick after the high-byte write loads the full 16-bit value into the count. Before that tick, the count is unchanged.
- R3: While running with the gate high, each tick lowers the count by exactly one.
- R4: While the count equals 1, with the gate high, the output is low. The next tick reloads the initial value and returns the output high, so the output falls once every N ticks.
- R5: An initial count of 0 acts as 65,536. After loading, the next tick gives 0xFFFF, and a full period lasts 65,536 ticks.
- R6: While the gate is low, ticks leave the count unchanged and the output is high. A falling gate releases a low output by the next clock.
- R7: A rising gate on a loaded channel makes the next tick reload the initial value.
- R8: A data-address read presents the low byte of the live count and then the high byte, alternating. Reads never change the count. The read pointer is independent of the write pointer.
- R9: An accepted control word returns both byte pointers to the low byte, stops counting and drives the output high. The output stays high until a new count is loaded.
- R10: After reset, the count is 0, the output is high, both pointers select the low byte, and ticks have no effect until a count is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-clock strobe per counting tick |
| gate_en | input | 1 | Gate level; 1 allows counting |
| bus_addr | input | 1 | 0 selects the data address, 1 selects the control address |
| bus_wr | input | 1 | Write strobe, one clock per byte |
| bus_rd | input | 1 | Read strobe for the data address; advances the read pointer |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Count byte chosen by the read pointer |
| out_pulse | output | 1 | Rate-generator output; low for one tick per period |

## Verification
A count register that is off by one step shows up on the next two-byte read. It also shifts the low pulse of `out_pulse` by one tick in every period after that. A write or read pointer that is out of phase swaps the bytes at once. The bench catches this with byte values whose low and high halves differ. A missed reload, or one that comes too early, is exposed within one period by checking the output low at count 1 and the value read back after the wrap.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

    // Control word layout; the bit positions set the accepted encoding.
    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    localparam logic [1:0] SEL_THIS_CHAN = 2'b10;
    localparam logic [1:0] ACC_LO_HI     = 2'b11;
    localparam logic [2:0] MODE_RATE_GEN = 3'b010;
    localparam logic       CNT_BINARY    = 1'b0;

    typedef enum logic {
        PORT_DATA = 1'b0,
        PORT_CTRL = 1'b1
    } port_sel_e;

endpackage

// File: rtl/pit_cw_decode.sv
module pit_cw_decode
    import pit_chan_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic              cw_accept,
    output logic              data_wr,
    output logic              data_rd
);

    ctrl_word_t cw;
    logic       fields_ok;

    always_comb begin
        cw        = ctrl_word_t'(bus_wdata[7:0]);
        fields_ok = (cw.sel == SEL_THIS_CHAN) && (cw.acc == ACC_LO_HI) &&
                    (cw.mode == MODE_RATE_GEN) && (cw.bcd == CNT_BINARY);
        cw_accept = bus_wr && (bus_addr == PORT_CTRL) && fields_ok;
        data_wr   = bus_wr && (bus_addr == PORT_DATA);
        data_rd   = bus_rd && (bus_addr == PORT_DATA);
    end

endmodule

// File: rtl/pit_byte_io.sv
module pit_byte_io #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_accept,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count_i,
    output logic [CNT_W-1:0]  init_o,
    output logic              load_req,
    output logic [BYTE_W-1:0] rdata
);

    typedef struct packed {
        logic              wptr;
        logic              rptr;
        logic [BYTE_W-1:0] lo_stage;
        logic [CNT_W-1:0]  init;
    } io_state_t;

    io_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        load_req = 1'b0;
        if (cw_accept) begin
            s_d.wptr = 1'b0;
            s_d.rptr = 1'b0;
        end else begin
            if (data_wr) begin
                if (!s_q.wptr) begin
                    s_d.lo_stage = wdata;
                    s_d.wptr     = 1'b1;
                end else begin
                    s_d.init = {wdata, s_q.lo_stage};
                    s_d.wptr = 1'b0;
                    load_req = 1'b1;
                end
            end
            if (data_rd) begin
                s_d.rptr = ~s_q.rptr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign init_o = s_q.init;
    assign rdata  = s_q.rptr ? count_i[CNT_W-1:BYTE_W] : count_i[BYTE_W-1:0];

    // R8: every data read flips the read pointer
    p_rptr_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !cw_accept) |=> (s_q.rptr != $past(s_q.rptr)));

    // R9: an accepted control word parks both pointers on the low byte
    p_ptr_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cw_accept |=> (!s_q.wptr && !s_q.rptr));

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             gate_en,
    input  logic             clear,
    input  logic             load_req,
    input  logic [CNT_W-1:0] init_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
        logic             armed;
        logic             load_pend;
        logic             gate_q;
    } core_state_t;

    core_state_t s_d, s_q;
    logic        gate_rise;
    logic        new_req;

    always_comb begin
        s_d        = s_q;
        s_d.gate_q = gate_en;
        gate_rise  = gate_en && !s_q.gate_q;
        new_req    = 1'b0;
        if (clear) begin
            s_d.running   = 1'b0;
            s_d.armed     = 1'b0;
            s_d.load_pend = 1'b0;
        end else begin
            new_req = load_req || (gate_rise && s_q.armed);
            if (load_req) s_d.armed = 1'b1;
            if (tick_en && s_q.load_pend) begin
                s_d.count     = init_i;
                s_d.running   = 1'b1;
                s_d.load_pend = new_req;
            end else begin
                s_d.load_pend = s_q.load_pend || new_req;
                if (tick_en && s_q.running && gate_en && s_q.gate_q) begin
                    if (s_q.count == CNT_ONE) s_d.count = init_i;
                    else                      s_d.count = s_q.count - CNT_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.count;
    assign out_o   = !(s_q.running && s_q.gate_q && (s_q.count == CNT_ONE));

    // R2: a pending load takes the initial value on the tick
    p_load_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && s_q.load_pend && !clear) |=>
        ((s_q.count == $past(init_i)) && s_q.running));

    // R3: an enabled tick steps the count down by one
    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && s_q.running && gate_en && s_q.gate_q && !s_q.load_pend &&
         !clear && (s_q.count != CNT_ONE)) |=> (s_q.count == $past(s_q.count) - CNT_ONE));

    // R4: the tick at count one reloads the initial value
    p_reload_at_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && s_q.running && gate_en && s_q.gate_q && !s_q.load_pend &&
         !clear && (s_q.count == CNT_ONE)) |=> (s_q.count == $past(init_i)));

    // R6: ticks with the gate low leave the count alone
    p_hold_gate_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !gate_en && !s_q.load_pend && !clear) |=> $stable(s_q.count));

    // R6: a falling gate releases the output by the next clock
    p_gate_fall_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && s_q.gate_q) |=> out_o);

endmodule

// File: rtl/pit_rate_channel.sv
module pit_rate_channel #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              gate_en,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              out_pulse
);

    logic             cw_accept;
    logic             data_wr;
    logic             data_rd;
    logic             load_req;
    logic [CNT_W-1:0] init_val;
    logic [CNT_W-1:0] count_val;

    pit_cw_decode #(.BYTE_W(BYTE_W)) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .cw_accept (cw_accept),
        .data_wr   (data_wr),
        .data_rd   (data_rd)
    );

    pit_byte_io #(.BYTE_W(BYTE_W)) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .cw_accept (cw_accept),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .wdata     (bus_wdata),
        .count_i   (count_val),
        .init_o    (init_val),
        .load_req  (load_req),
        .rdata     (bus_rdata)
    );

    pit_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .gate_en  (gate_en),
        .clear    (cw_accept),
        .load_req (load_req),
        .init_i   (init_val),
        .count_o  (count_val),
        .out_o    (out_pulse)
    );

    // R9: the output is high right after an accepted control word
    p_cw_out_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cw_accept |=> out_pulse);

    // R1: a rejected control-address write leaves the count untouched
    p_reject_cw_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && !cw_accept && !tick_en) |=> $stable(count_val));

endmodule

// File: tb/test_pit_rate_channel.sv
module test_pit_rate_channel;

    localparam logic [2:0] OP_OUT  = 3'd0;
    localparam logic [2:0] OP_RD   = 3'd1;
    localparam logic [2:0] OP_GATE = 3'd2;
    localparam logic [2:0] OP_CW   = 3'd3;
    localparam logic [2:0] OP_WR   = 3'd4;
    localparam logic [2:0] OP_TICK = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] arg;
        logic [3:0]  req;
    } step_t;

    localparam int N_STEPS = 90;
    localparam step_t STEPS [N_STEPS] = '{
        '{OP_OUT, 16'h1, 4'd10}, '{OP_RD, 16'h00, 4'd10}, '{OP_RD, 16'h00, 4'd10},   // R10
        '{OP_GATE, 16'h1, 4'd6}, '{OP_CW, 16'hB4, 4'd1},
        '{OP_WR, 16'h05, 4'd2}, '{OP_WR, 16'h00, 4'd2},                               // R2
        '{OP_RD, 16'h00, 4'd2}, '{OP_RD, 16'h00, 4'd2},
        '{OP_TICK, 16'd1, 4'd2}, '{OP_RD, 16'h05, 4'd2}, '{OP_RD, 16'h00, 4'd2},
        '{OP_OUT, 16'h1, 4'd4},
        '{OP_TICK, 16'd1, 4'd3}, '{OP_RD, 16'h04, 4'd3}, '{OP_RD, 16'h00, 4'd3},     // R3
        '{OP_TICK, 16'd3, 4'd4}, '{OP_OUT, 16'h0, 4'd4},                              // R4
        '{OP_RD, 16'h01, 4'd4}, '{OP_RD, 16'h00, 4'd4},
        '{OP_TICK, 16'd1, 4'd4}, '{OP_OUT, 16'h1, 4'd4},
        '{OP_RD, 16'h05, 4'd4}, '{OP_RD, 16'h00, 4'd4},
        '{OP_TICK, 16'd2, 4'd3}, '{OP_GATE, 16'h0, 4'd6}, '{OP_TICK, 16'd3, 4'd6},   // R6
        '{OP_RD, 16'h03, 4'd6}, '{OP_RD, 16'h00, 4'd6}, '{OP_OUT, 16'h1, 4'd6},
        '{OP_GATE, 16'h1, 4'd7}, '{OP_TICK, 16'd1, 4'd7},                             // R7
        '{OP_RD, 16'h05, 4'd7}, '{OP_RD, 16'h00, 4'd7},
        '{OP_TICK, 16'd1, 4'd3}, '{OP_CW, 16'h74, 4'd1}, '{OP_CW, 16'hB6, 4'd1},     // R1
        '{OP_TICK, 16'd1, 4'd1}, '{OP_RD, 16'h03, 4'd1}, '{OP_RD, 16'h00, 4'd1},
        '{OP_TICK, 16'd2, 4'd4}, '{OP_OUT, 16'h0, 4'd4},
        '{OP_GATE, 16'h0, 4'd6}, '{OP_OUT, 16'h1, 4'd6},
        '{OP_GATE, 16'h1, 4'd7}, '{OP_TICK, 16'd1, 4'd7},
        '{OP_RD, 16'h05, 4'd7}, '{OP_RD, 16'h00, 4'd7},
        '{OP_TICK, 16'd4, 4'd4}, '{OP_OUT, 16'h0, 4'd4},
        '{OP_CW, 16'hB4, 4'd9}, '{OP_OUT, 16'h1, 4'd9}, '{OP_TICK, 16'd2, 4'd9},     // R9
        '{OP_RD, 16'h01, 4'd9}, '{OP_RD, 16'h00, 4'd9},
        '{OP_WR, 16'h34, 4'd9}, '{OP_CW, 16'hB4, 4'd9},
        '{OP_WR, 16'h0A, 4'd9}, '{OP_WR, 16'h00, 4'd9}, '{OP_TICK, 16'd1, 4'd9},
        '{OP_RD, 16'h0A, 4'd9}, '{OP_RD, 16'h00, 4'd9},
        '{OP_RD, 16'h0A, 4'd8}, '{OP_WR, 16'h0C, 4'd8}, '{OP_WR, 16'h01, 4'd8},     // R8
        '{OP_RD, 16'h00, 4'd8}, '{OP_TICK, 16'd1, 4'd8},
        '{OP_RD, 16'h0C, 4'd8}, '{OP_RD, 16'h01, 4'd8},
        '{OP_TICK, 16'd1, 4'd8}, '{OP_RD, 16'h0B, 4'd8}, '{OP_RD, 16'h01, 4'd8},
        '{OP_CW, 16'hB4, 4'd5}, '{OP_WR, 16'h00, 4'd5}, '{OP_WR, 16'h00, 4'd5},     // R5
        '{OP_TICK, 16'd1, 4'd5}, '{OP_RD, 16'h00, 4'd5}, '{OP_RD, 16'h00, 4'd5},
        '{OP_TICK, 16'd1, 4'd5}, '{OP_RD, 16'hFF, 4'd5}, '{OP_RD, 16'hFF, 4'd5},
        '{OP_OUT, 16'h1, 4'd5}, '{OP_TICK, 16'd65534, 4'd5}, '{OP_OUT, 16'h0, 4'd5},
        '{OP_RD, 16'h01, 4'd5}, '{OP_RD, 16'h00, 4'd5},
        '{OP_TICK, 16'd1, 4'd5}, '{OP_OUT, 16'h1, 4'd5},
        '{OP_RD, 16'h00, 4'd5}, '{OP_RD, 16'h00, 4'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       gate_en = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       out_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pit_rate_channel i_pit_rate_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .gate_en   (gate_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .out_pulse (out_pulse)
    );

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic addr, input logic [7:0] val);
        bus_addr  = addr;
        bus_wdata = val;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read_byte(input int req, input logic [7:0] exp);
        check(req, {8'h00, bus_rdata}, {8'h00, exp});
        bus_addr = 1'b0;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic run_step(input step_t s);
        case (s.op)
            OP_OUT:  check(int'(s.req), {15'h0, out_pulse}, s.arg);
            OP_RD:   read_byte(int'(s.req), s.arg[7:0]);
            OP_GATE: begin gate_en = s.arg[0]; @(negedge clk); end
            OP_CW:   bus_write(1'b1, s.arg[7:0]);
            OP_WR:   bus_write(1'b0, s.arg[7:0]);
            OP_TICK: ticks(int'(s.arg));
            default: ;
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < N_STEPS; i++) run_step(STEPS[i]);

        // R10: reset mid-run, then ticks without a load do nothing
        ticks(1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(10, {15'h0, out_pulse}, 16'h1);
        read_byte(10, 8'h00);
        read_byte(10, 8'h00);
        ticks(3);
        read_byte(10, 8'h00);
        read_byte(10, 8'h00);
        check(10, {15'h0, out_pulse}, 16'h1);

        // R4: period of two ticks gives alternating output
        bus_write(1'b1, 8'hB4);
        bus_write(1'b0, 8'h02);
        bus_write(1'b0, 8'h00);
        ticks(1);
        check(4, {15'h0, out_pulse}, 16'h1);
        ticks(1);
        check(4, {15'h0, out_pulse}, 16'h0);
        ticks(1);
        check(4, {15'h0, out_pulse}, 16'h1);
        read_byte(4, 8'h02);
        read_byte(4, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule